// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits between a simple host port and a 4-bit EDO DRAM. The host presents a request that carries a write flag, a combined row/column address and write data. The controller turns each request into a strobe sequence on the DRAM pins. These pins are an active-low row strobe, an active-low column strobe, an active-low write enable, an active-low output enable, a shared address bus that carries the row and then the column, and a bidirectional data bus. A completed read comes back on the host side with a one-clock valid pulse.

The controller leaves a row open after an access, so that later requests to the same row only need a new column strobe. A request to a different row first closes the page and waits out the row precharge before it opens the new row. A page that sees no request for a set number of clocks is closed as well. Reads are sampled in the column precharge phase, while the DRAM holds its output valid after the column strobe has risen. Every write sets the write enable before the column strobe falls. As a result the DRAM never drives the bus during a write.

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is held, and in the clock after it is released, the row strobe, column strobe, write enable and output enable are all high, `ready` is 1, `rvalid` is 0 and `dram_dq` is released (all bits Z).
- R2: A new page is opened by driving the row half of `req_addr` (bits [ROW_W+COL_W-1:COL_W]) on `dram_addr` and pulling the row strobe low. The column strobe then falls no earlier than T_RCD clocks later, with the column half (bits [COL_W-1:0]) on `dram_addr` and every `dram_addr` bit at or above COL_W at 0. The column strobe is only low while the row strobe is low.
- R3: While a page is open, a request to the same row is served by a new column strobe only, with no new falling edge of the row strobe.
- R4: A request to a different row raises the row strobe while the column strobe is high. The row strobe then stays high for exactly T_RP clocks before it falls with the new row address. In any case it never stays high for fewer than T_RP clocks between two pages.
- R5: When a page is open and no request arrives, the row strobe rises after exactly IDLE_LIM consecutive clocks with `ready` at 1. The next request then opens the row again.
- R6: Each column strobe stays low for exactly T_CAS clocks. Within one page, the column strobe stays high for at least T_CP clocks between two strobes.
- R7: Writes are early writes. The write enable is already low in the clock before the column strobe falls, the output enable is high, and `dram_dq` carries the write data when the column strobe falls.
- R8: For a read, the write enable is high and the output enable is low when the column strobe falls. `rdata` equals the data that the DRAM holds at that row and column, captured after the column strobe has risen again.
- R9: The controller drives `dram_dq` only while the write enable is low. At all other times the bus is either released or driven by the DRAM.
- R10: `ready` goes to 0 in the clock after a request is accepted (`req_valid` and `ready` both 1) and stays 0 until the request is served. `rvalid` is a one-clock pulse, given once per read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row in the upper bits, column in the lower COL_W bits |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | Controller can accept a request this clock |
| rdata | output | DATA_W | Read data |
| rvalid | output | 1 | One-clock pulse when `rdata` holds a completed read |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq | inout | DATA_W | Bidirectional data bus |

## Verification
The bench uses several request patterns, and each one separates a different fault. Back-to-back writes and reads in one row show whether a page hit toggles only the column strobe or wrongly reopens the row. A jump to another row checks the close, the exact precharge length and the reopening with the new row address. A long silence after an access measures the idle timeout down to the clock, and a request that follows it must open the page again. A long pseudo-random mix follows. It uses four rows, columns up to the top value, and gaps that fall either short of or beyond the timeout. Its read data is compared against a reference memory in the bench. In every clock a pin-level DRAM model checks the strobe widths, early write, bus release and column-phase address bits.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // page closed, precharge met
    ST_RCD  = 3'd1,  // row strobe low, waiting before column strobe
    ST_COL  = 3'd2,  // page hit: one setup clock for address and write enable
    ST_CASL = 3'd3,  // column strobe low
    ST_CP   = 3'd4,  // column precharge, read sampled at its end
    ST_OPEN = 3'd5,  // page open, waiting for a request
    ST_RP   = 3'd6   // row strobe high, precharge
  } edo_state_e;

endpackage

// File: rtl/edo_phase_timer.sv
module edo_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/edo_page_tracker.sv
module edo_page_tracker #(
  parameter int ROW_W    = 12,
  parameter int IDLE_LIM = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  input  logic             wait_i,
  output logic             hit_o,
  output logic             timeout_o
);

  localparam int IW = $clog2(IDLE_LIM + 1);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [IW-1:0]    idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (open_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (close_i) begin
      open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !wait_i) begin
      idle_q <= '0;
    end else if (!timeout_o) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assign hit_o     = open_q && (row_q == cmp_row_i);
  assign timeout_o = wait_i && (idle_q == IW'(IDLE_LIM - 1));

  // R5: a timeout is only raised while a page is actually open
  assert_timeout_open_R5: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> open_q);

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W    = 12,
  parameter int COL_W    = 10,
  parameter int DATA_W   = 4,
  parameter int T_RCD    = 2,
  parameter int T_CAS    = 2,
  parameter int T_CP     = 1,
  parameter int T_RP     = 3,
  parameter int IDLE_LIM = 8
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       req_valid,
  input  logic                                       req_write,
  input  logic [ROW_W+COL_W-1:0]                     req_addr,
  input  logic [DATA_W-1:0]                          req_wdata,
  output logic                                       ready,
  output logic [DATA_W-1:0]                          rdata,
  output logic                                       rvalid,
  output logic                                       dram_ras_n,
  output logic                                       dram_cas_n,
  output logic                                       dram_we_n,
  output logic                                       dram_oe_n,
  output logic [(ROW_W > COL_W ? ROW_W : COL_W)-1:0] dram_addr,
  inout  wire  [DATA_W-1:0]                          dram_dq
);

  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TMAX_A = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TMAX_B = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TW     = $clog2(TMAX + 1);

  edo_state_e st_q, st_nx;

  logic [ROW_W-1:0]  req_row, cur_row;
  logic [COL_W-1:0]  req_col, cur_col;
  logic              cur_wr, pend_q;
  logic [DATA_W-1:0] dq_out_q;
  logic              dq_oe_q;
  logic              accept, t_done, t_load, hit, timeout;
  logic [TW-1:0]     t_val;
  logic              trk_open, trk_close, trk_wait;
  logic [ROW_W-1:0]  trk_row;

  assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];
  assign accept  = ready && req_valid;

  assign dram_dq = dq_oe_q ? dq_out_q : {DATA_W{1'bz}};

  edo_phase_timer #(.CNT_W(TW)) u_timer (
    .clk(clk), .rst(rst), .load_i(t_load), .val_i(t_val), .done_o(t_done)
  );

  edo_page_tracker #(.ROW_W(ROW_W), .IDLE_LIM(IDLE_LIM)) u_track (
    .clk(clk), .rst(rst), .open_i(trk_open), .row_i(trk_row),
    .close_i(trk_close), .cmp_row_i(req_row), .wait_i(trk_wait),
    .hit_o(hit), .timeout_o(timeout)
  );

  assign trk_open  = ((st_q == ST_IDLE) && accept) || ((st_q == ST_RP) && t_done && pend_q);
  assign trk_row   = (st_q == ST_IDLE) ? req_row : cur_row;
  assign trk_close = (st_q == ST_OPEN) && ((accept && !hit) || (!req_valid && timeout));
  assign trk_wait  = (st_q == ST_OPEN) && !req_valid;

  // next state and phase timer loads
  always_comb begin
    st_nx  = st_q;
    t_load = 1'b0;
    t_val  = '0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_nx = ST_RCD; t_load = 1'b1; t_val = TW'(T_RCD - 1);
      end
      ST_RCD: if (t_done) begin
        st_nx = ST_CASL; t_load = 1'b1; t_val = TW'(T_CAS - 1);
      end
      ST_COL: begin
        st_nx = ST_CASL; t_load = 1'b1; t_val = TW'(T_CAS - 1);
      end
      ST_CASL: if (t_done) begin
        st_nx = ST_CP; t_load = 1'b1; t_val = TW'(T_CP - 1);
      end
      ST_CP: if (t_done) st_nx = ST_OPEN;
      ST_OPEN: begin
        if (accept && hit) begin
          st_nx = ST_COL;
        end else if (accept || timeout) begin
          st_nx = ST_RP; t_load = 1'b1; t_val = TW'(T_RP - 1);
        end
      end
      ST_RP: if (t_done) begin
        if (pend_q) begin
          st_nx = ST_RCD; t_load = 1'b1; t_val = TW'(T_RCD - 1);
        end else begin
          st_nx = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  // registered pin and host outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      ready      <= 1'b1;
      rvalid     <= 1'b0;
      rdata      <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_oe_n  <= 1'b1;
      dram_addr  <= '0;
      dq_oe_q    <= 1'b0;
      dq_out_q   <= '0;
      cur_row    <= '0;
      cur_col    <= '0;
      cur_wr     <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      st_q   <= st_nx;
      rvalid <= 1'b0;
      if (accept) begin
        cur_row  <= req_row;
        cur_col  <= req_col;
        cur_wr   <= req_write;
        dq_out_q <= req_wdata;
      end
      unique case (st_q)
        ST_IDLE: if (accept) begin
          ready      <= 1'b0;
          pend_q     <= 1'b0;
          dram_ras_n <= 1'b0;
          dram_addr  <= ADDR_W'(req_row);
          dram_we_n  <= !req_write;
          dram_oe_n  <= req_write;
          dq_oe_q    <= req_write;
        end
        ST_RCD: if (t_done) begin
          dram_cas_n <= 1'b0;
          dram_addr  <= ADDR_W'(cur_col);
        end
        ST_COL: dram_cas_n <= 1'b0;
        ST_CASL: if (t_done) begin
          dram_cas_n <= 1'b1;
          dram_we_n  <= 1'b1;
          dq_oe_q    <= 1'b0;
        end
        ST_CP: if (t_done) begin
          if (!cur_wr) begin
            rdata  <= dram_dq;
            rvalid <= 1'b1;
          end
          dram_oe_n <= 1'b1;
          ready     <= 1'b1;
        end
        ST_OPEN: begin
          if (accept) begin
            ready <= 1'b0;
            if (hit) begin
              dram_addr <= ADDR_W'(req_col);
              dram_we_n <= !req_write;
              dram_oe_n <= req_write;
              dq_oe_q   <= req_write;
            end else begin
              dram_ras_n <= 1'b1;
              pend_q     <= 1'b1;
            end
          end else if (timeout) begin
            ready      <= 1'b0;
            dram_ras_n <= 1'b1;
            pend_q     <= 1'b0;
          end
        end
        ST_RP: if (t_done) begin
          if (pend_q) begin
            dram_ras_n <= 1'b0;
            dram_addr  <= ADDR_W'(cur_row);
            dram_we_n  <= !cur_wr;
            dram_oe_n  <= cur_wr;
            dq_oe_q    <= cur_wr;
          end else begin
            ready <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: column strobe never low with the row closed
  assert_cas_in_page_R2: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);

  // R2: column phase carries zeros above the column field
  if (ADDR_W > COL_W) begin : g_upper_chk
    assert_col_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
      $fell(dram_cas_n) |-> (dram_addr[ADDR_W-1:COL_W] == '0));
  end

  // R4: the page closes only with the column strobe high
  assert_close_cas_high_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras_n) |-> dram_cas_n);

  // R7: write enable settles before the column strobe falls
  assert_early_write_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

  // R9: the bus is driven only in a write with the DRAM outputs off
  assert_dq_write_only_R9: assert property (@(posedge clk) disable iff (rst)
    dq_oe_q |-> (!dram_we_n && dram_oe_n));

  // R10: busy after acceptance, single-clock read pulse
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid) |=> !ready);
  assert_rvalid_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

endmodule

// File: tb/edo_page_ctrl_tb.sv
`timescale 1ns/1ps
module edo_page_ctrl_tb;

  localparam int ROW_W = 12, COL_W = 10, DATA_W = 4;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 3, IDLE_LIM = 8;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic ready, rvalid, ras_n, cas_n, we_n, oe_n;
  logic [DATA_W-1:0] rdata;
  logic [11:0] addr;
  wire  [DATA_W-1:0] dq;

  logic mdl_col_ok = 1'b0;
  logic [DATA_W-1:0] mdl_q = '0;
  wire  mdl_drv = mdl_col_ok && !ras_n && !oe_n && we_n;
  assign dq = mdl_drv ? mdl_q : {DATA_W{1'bz}};

  edo_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .IDLE_LIM(IDLE_LIM)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rdata(rdata),
    .rvalid(rvalid), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_oe_n(oe_n), .dram_addr(addr), .dram_dq(dq));

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] init_val(input int k);
    return 4'(k ^ (k >> 4) ^ (k >> 12));
  endfunction

  logic [3:0] dmem [int];   // DRAM model array
  logic [3:0] refm [int];   // host-side reference

  // pin-level DRAM model and protocol monitor
  logic prev_ras = 1, prev_cas = 1, prev_we = 1, prev_rv = 0, closed_once = 0, first_cas = 0;
  logic [ROW_W-1:0] mrow = '0;
  int hi_run = 0, pre_cas = 0, lo_run = 0, idle_run = 0;
  int ras_falls = 0, last_rp = 0, last_idle = -1, rv_cnt = 0;

  always @(negedge clk) begin
    if (rst) begin
      prev_ras = 1; prev_cas = 1; prev_we = 1; prev_rv = 0; mdl_col_ok = 0;
    end else begin
      automatic bit ras_fall = prev_ras && !ras_n;
      automatic bit ras_rise = !prev_ras && ras_n;
      automatic bit cas_fall = prev_cas && !cas_n;
      automatic bit cas_rise = !prev_cas && cas_n;
      if (ras_fall) begin
        mrow = addr[ROW_W-1:0]; ras_falls++; last_rp = hi_run;
        if (closed_once) chk(hi_run >= T_RP, "R4 row precharge length", hi_run, T_RP);
        pre_cas = 0; first_cas = 1;
      end
      if (ras_rise) begin
        closed_once = 1; hi_run = 0; mdl_col_ok = 0; last_idle = idle_run;
        chk(cas_n, "R4 column strobe high at close", cas_n, 1);
      end
      if (ras_n) hi_run++;
      if (cas_fall) begin
        automatic int k = int'({mrow, addr[COL_W-1:0]});
        if (first_cas) chk(pre_cas >= T_RCD, "R2 row-to-column delay", pre_cas, T_RCD);
        else chk(pre_cas >= T_CP, "R6 column precharge", pre_cas, T_CP);
        chk(addr[11:COL_W] == 0, "R2 upper address bits in column phase", addr[11:COL_W], 0);
        chk(!ras_n, "R2 column strobe inside page", ras_n, 0);
        first_cas = 0; pre_cas = 0; lo_run = 0;
        if (!we_n) begin
          chk(!prev_we, "R7 write enable low before column strobe", prev_we, 0);
          chk(oe_n, "R7 output enable high in write", oe_n, 1);
          chk(^dq !== 1'bx, "R7 write data driven", 0, 0);
          dmem[k] = dq;
        end else begin
          chk(!oe_n, "R8 output enable low in read", oe_n, 0);
          mdl_q = dmem.exists(k) ? dmem[k] : init_val(k);
          mdl_col_ok = 1;
        end
      end
      if (!ras_n && cas_n) pre_cas++;
      if (!cas_n) lo_run++;
      if (cas_rise) chk(lo_run == T_CAS, "R6 column strobe low width", lo_run, T_CAS);
      if (we_n && !mdl_drv) chk(dq === 4'bzzzz, "R9 bus released", int'(dq), 0);
      if (!we_n) chk(oe_n, "R9 no output enable in write", oe_n, 1);
      if (rvalid) begin
        rv_cnt++;
        chk(!prev_rv, "R10 rvalid single clock", prev_rv, 0);
      end
      if (!ras_n && ready && !req_valid) idle_run++; else idle_run = 0;
      prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n; prev_rv = rvalid;
    end
  end

  int reads = 0;

  task automatic access(input bit wr, input int row, input int col, input logic [3:0] wd);
    automatic int k = (row << COL_W) | col;
    do begin @(posedge clk); #1; end while (!ready);
    req_valid = 1; req_write = wr; req_addr = (ROW_W+COL_W)'(k); req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 0;
    chk(!ready, "R10 ready low after accept", ready, 0);
    if (wr) refm[k] = wd;
    else begin
      automatic logic [3:0] e = refm.exists(k) ? refm[k] : init_val(k);
      reads++;
      do @(negedge clk); while (!rvalid);
      chk(rdata == e, "R8 read data", rdata, e);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
    end
  end

  initial begin
    automatic int f0;
    automatic logic [31:0] lf = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high in reset", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(ready == 1 && rvalid == 0, "R1 host outputs in reset", {ready, rvalid}, 2);
    #1 rst = 0;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high after reset", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(dq === 4'bzzzz, "R1 bus released", int'(dq), 0);

    // same-row page hits
    f0 = ras_falls;
    access(1, 5, 3, 4'hA);
    access(1, 5, 4, 4'h6);
    access(0, 5, 3, 0);
    access(0, 5, 4, 0);
    chk(ras_falls - f0 == 1, "R3 hits keep row open", ras_falls - f0, 1);

    // row miss
    f0 = ras_falls;
    access(0, 9, 7, 0);
    chk(ras_falls - f0 == 1, "R4 miss reopens", ras_falls - f0, 1);
    chk(last_rp == T_RP, "R4 exact precharge on miss", last_rp, T_RP);
    access(1, 9, 1023, 4'h5);
    access(0, 9, 1023, 0);

    // idle timeout
    repeat (3 * IDLE_LIM) @(posedge clk);
    @(negedge clk);
    chk(ras_n == 1, "R5 page closed after idle", ras_n, 1);
    chk(last_idle == IDLE_LIM, "R5 idle clocks before close", last_idle, IDLE_LIM);
    f0 = ras_falls;
    access(0, 9, 7, 0);
    chk(ras_falls - f0 == 1, "R5 reopen after timeout", ras_falls - f0, 1);

    // pseudo-random mix
    for (int i = 0; i < 80; i++) begin
      automatic int rows[4] = '{5, 9, 300, 4095};
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      access(lf[0], rows[lf[2:1]], int'(lf[14:5]), lf[18:15]);
      if (lf[22:20] == 0) repeat (IDLE_LIM + 4) @(posedge clk);
    end

    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(rv_cnt == reads, "R10 one rvalid per read", rv_cnt, reads);
    done = 1;
    summary();
  end

endmodule